// File: doc/BRIEF.md
# Card Presence Debounce Detector

This block watches the mechanical presence switch of one smart-card slot and turns it into a clean card-inserted status. The raw switch level first passes through a short synchronizer. A programmable polarity then maps it to "present" or "absent". A run-length filter changes the status only after the selected number of identical consecutive samples. A 3-bit length code selects that number, from 4 up to 256 samples.

Every change of the filtered status sets a sticky insertion/extraction flag. A host read strobe clears the flag. The flag drives the interrupt output unless the slot's interrupt-disable input is high. An extraction also gives a one-cycle pulse, which the deactivation sequencer uses to start its automatic power-down.

Length code zero selects unfiltered operation. In that mode the status follows every synchronized sample. A combinational wake path also drives the interrupt straight from the switch, so a host whose clock is stopped can still be woken by an insertion.

Top module: `card_presence_detect`

## Requirements
- R1: Length code values 1 to 7 select 4, 8, 16, 32, 64, 128 and 256 identical consecutive samples. The switch level passes through a 2-stage synchronizer. The status takes the new level on the clock edge at which the run of identical samples reaches the selected length.
- R2: A sample that differs from the previous sample restarts the run count at one. A glitch shorter than the selected length leaves the status unchanged.
- R3: With the polarity input at 1, a high switch level means a card is present. With the polarity input at 0, a low switch level means a card is present.
- R4: Every change of the filtered status, insertion or extraction, sets the flag on the same edge as the status change.
- R5: A read strobe clears the flag on the next edge. A status change on the same edge as a read strobe leaves the flag set.
- R6: The interrupt output equals the flag while the disable input is 0. While the disable input is 1, the interrupt output stays low and the flag still sets.
- R7: With length code 0, the status follows each synchronized sample after one sample. While the switch shows a card present, the registered status is still 0 and interrupts are not disabled, the interrupt output is driven high combinationally, with no clock running.
- R8: The extraction output is high for exactly one cycle, in the cycle after the status falls from 1 to 0.
- R9: After reset, the status, flag, extraction output and interrupt output are 0. The interrupt output is 0 as long as the length code is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| switch_i | input | 1 | Raw presence switch level |
| pol_high_i | input | 1 | 1: high level means a card is present |
| len_sel_i | input | 3 | Filter length code (0 = unfiltered) |
| irq_dis_i | input | 1 | Interrupt disable for this slot |
| flag_rd_i | input | 1 | Host read strobe that clears the flag |
| card_in_o | output | 1 | Debounced card-present status |
| chg_flag_o | output | 1 | Sticky insertion/extraction flag |
| irq_o | output | 1 | Interrupt request |
| extract_o | output | 1 | One-cycle extraction pulse |

## Verification
The bench targets four failure modes:
- Off-by-one run counting at every length code. A design that counts from zero, or compares with the wrong bound, moves the status one edge early or late.
- Bounce patterns just shorter than the filter length. A counter that does not restart on a differing sample would let them through.
- A read strobe on the very edge of a status change. This exposes a clear-over-set priority, which would silently lose an insertion event.
- The unfiltered mode with the clock halted. A design without the combinational wake term would leave the host asleep after an insertion.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int unsigned CPD_SEL_W   = 3;
  localparam int unsigned CPD_MAX_RUN = 256;
  localparam int unsigned CPD_CNT_W   = $clog2(CPD_MAX_RUN + 1);

  typedef logic [CPD_CNT_W-1:0] cpd_cnt_t;

  // code 0 -> 1 sample, code k -> 2^(k+1) samples
  function automatic cpd_cnt_t cpd_run_len(input logic [CPD_SEL_W-1:0] sel);
    cpd_cnt_t r;
    if (sel == '0) r = cpd_cnt_t'(1);
    else           r = cpd_cnt_t'(1) << (int'(sel) + 1);
    return r;
  endfunction
endpackage

// File: rtl/cpd_sync.sv
module cpd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cpd_filter.sv
module cpd_filter
  import cpd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     smp_i,
  input  cpd_cnt_t len_i,
  output logic     stat_o,
  output logic     chg_o
);
  logic     prev_q, stat_q;
  cpd_cnt_t cnt_q, run_d;

  always_comb begin
    if (smp_i != prev_q)                    run_d = cpd_cnt_t'(1);
    else if (cnt_q == cpd_cnt_t'(CPD_MAX_RUN)) run_d = cnt_q;
    else                                    run_d = cnt_q + cpd_cnt_t'(1);
  end

  assign chg_o  = (run_d >= len_i) && (smp_i != stat_q);
  assign stat_o = stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= smp_i;
      cnt_q  <= run_d;
      if (chg_o) stat_q <= smp_i;
    end
  end

  // status only ever moves to the level that was being sampled
  assert_stat_follows_sample_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q != $past(stat_q)) |-> (stat_q == $past(smp_i)));

  assert_run_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cpd_cnt_t'(CPD_MAX_RUN));
endmodule

// File: rtl/cpd_flag.sv
module cpd_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_i,
  input  logic new_stat_i,
  input  logic rd_i,
  input  logic dis_i,
  input  logic wake_i,
  output logic flag_o,
  output logic irq_o,
  output logic ext_o
);
  logic flag_q, ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      if (chg_i)     flag_q <= 1'b1;  // set beats clear
      else if (rd_i) flag_q <= 1'b0;
      ext_q <= chg_i & ~new_stat_i;
    end
  end

  assign flag_o = flag_q;
  assign ext_o  = ext_q;
  assign irq_o  = (flag_q & ~dis_i) | wake_i;

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i |=> flag_q);

  assert_rd_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !chg_i) |=> !flag_q);

  assert_ext_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q |=> !ext_q);
endmodule

// File: rtl/card_presence_detect.sv
module card_presence_detect
  import cpd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 switch_i,
  input  logic                 pol_high_i,
  input  logic [CPD_SEL_W-1:0] len_sel_i,
  input  logic                 irq_dis_i,
  input  logic                 flag_rd_i,
  output logic                 card_in_o,
  output logic                 chg_flag_o,
  output logic                 irq_o,
  output logic                 extract_o
);
  logic sw_sync, pres_smp, pres_raw, stat, chg, wake;

  cpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (switch_i),
    .q_o   (sw_sync)
  );

  assign pres_smp = ~(sw_sync ^ pol_high_i);
  assign pres_raw = ~(switch_i ^ pol_high_i);

  cpd_filter u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .smp_i (pres_smp),
    .len_i (cpd_run_len(len_sel_i)),
    .stat_o(stat),
    .chg_o (chg)
  );

  // unfiltered mode: clockless wake straight from the switch
  assign wake = (len_sel_i == '0) & pres_raw & ~stat & ~irq_dis_i;

  cpd_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chg_i     (chg),
    .new_stat_i(pres_smp),
    .rd_i      (flag_rd_i),
    .dis_i     (irq_dis_i),
    .wake_i    (wake),
    .flag_o    (chg_flag_o),
    .irq_o     (irq_o),
    .ext_o     (extract_o)
  );

  assign card_in_o = stat;

  assert_extract_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extract_o |-> (!card_in_o && $past(card_in_o)));

  assert_flag_on_change_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_in_o != $past(card_in_o)) |-> chg_flag_o);

  assert_irq_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_dis_i |-> !irq_o);
endmodule

// File: tb/tb_card_presence_detect.sv
module tb_card_presence_detect;
  localparam int CLK_P = 10;
  localparam int WDOG  = 150000;

  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic       sw = 1'b0, pol = 1'b1, dis = 1'b0, rd = 1'b0;
  logic [2:0] sel = 3'd3;
  logic       card_in, flag, irq, ext;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string req_tag = "R9";
  bit    done = 1'b0;

  card_presence_detect dut (
    .clk_i(clk), .rst_ni(rst_n), .switch_i(sw), .pol_high_i(pol),
    .len_sel_i(sel), .irq_dis_i(dis), .flag_rd_i(rd),
    .card_in_o(card_in), .chg_flag_o(flag), .irq_o(irq), .extract_o(ext)
  );

  always begin
    #(CLK_P/2);
    if (clk_run) clk = ~clk;
  end

  // behavioural reference model
  bit m_s1, m_s2, m_prev, m_stat, m_flag, m_ext;
  int m_run;

  function automatic int run_len(input logic [2:0] s);
    return (s == 0) ? 1 : (1 << (s + 1));
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit cur, pres, chg;
      cur  = m_s2;
      m_s2 = m_s1;
      m_s1 = sw;
      pres = (cur == pol);
      if (pres == m_prev) m_run = (m_run < 256) ? m_run + 1 : 256;
      else                m_run = 1;
      m_prev = pres;
      chg    = (m_run >= run_len(sel)) && (pres != m_stat);
      m_ext  = chg && !pres;
      if (chg) begin m_stat = pres; m_flag = 1'b1; end
      else if (rd) m_flag = 1'b0;
    end
  end

  task automatic check(input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req_tag, what, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n && !done) begin
      bit exp_irq;
      exp_irq = (m_flag && !dis) ||
                (sel == 0 && (sw == pol) && !m_stat && !dis);
      check("card_in_o", card_in, m_stat);
      check("chg_flag_o", flag, m_flag);
      check("irq_o", irq, exp_irq);
      check("extract_o", ext, m_ext);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic hold(input logic lvl, input int n);
    @(negedge clk);
    sw = lvl;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req_tag = "R9";
    check("reset card_in_o", card_in, 1'b0);
    check("reset chg_flag_o", flag, 1'b0);
    check("reset irq_o", irq, 1'b0);
    check("reset extract_o", ext, 1'b0);
    rst_n = 1'b1;

    // R1: exact length at every code, insert then extract
    req_tag = "R1";
    for (int s = 1; s < 8; s++) begin
      sel = 3'(s);
      hold(1'b1, run_len(3'(s)) + 6);
      hold(1'b0, run_len(3'(s)) + 6);
    end

    // R8: extraction pulse with flag read between events
    req_tag = "R8";
    sel = 3'd1;
    hold(1'b1, 12);
    @(negedge clk); rd = 1'b1; @(negedge clk); rd = 1'b0;
    hold(1'b0, 12);

    // R2: bounce shorter than the filter length
    req_tag = "R2";
    sel = 3'd3;
    for (int k = 0; k < 6; k++) begin
      hold(1'b1, 15);
      hold(1'b0, 3);
    end
    hold(1'b0, 25);

    // R3: active-low switch
    req_tag = "R3";
    pol = 1'b0;
    sel = 3'd2;
    hold(1'b1, 20);
    hold(1'b0, 20);
    hold(1'b1, 20);
    pol = 1'b1;
    hold(1'b0, 20);

    // R6: disabled interrupt, flag still set
    req_tag = "R6";
    dis = 1'b1;
    hold(1'b1, 20);
    check("flag while disabled", flag, 1'b1);
    check("irq while disabled", irq, 1'b0);
    dis = 1'b0;
    @(negedge clk);
    check("irq after enable", irq, 1'b1);

    // R5: read strobe held across a status change
    req_tag = "R5";
    @(negedge clk); rd = 1'b1;
    hold(1'b0, 20);
    rd = 1'b0;
    @(negedge clk);
    hold(1'b1, 30);
    @(negedge clk); rd = 1'b1; @(negedge clk); rd = 1'b0;

    // R4: random traffic at every code with sporadic reads
    req_tag = "R4";
    for (int s = 1; s < 8; s++) begin
      sel = 3'(s);
      for (int k = 0; k < 8; k++) begin
        rd = ($urandom_range(0, 3) == 0);
        dis = ($urandom_range(0, 4) == 0);
        hold(1'($urandom_range(0, 1)), 1 + $urandom_range(0, 2 * run_len(3'(s))));
      end
    end
    rd = 1'b0; dis = 1'b0;
    hold(1'b0, 300);
    @(negedge clk); rd = 1'b1; @(negedge clk); rd = 1'b0;

    // R7: unfiltered mode and clockless wake
    req_tag = "R7";
    sel = 3'd0;
    hold(1'b1, 6);
    hold(1'b0, 6);
    @(negedge clk); rd = 1'b1; @(negedge clk); rd = 1'b0;
    @(negedge clk);
    clk_run = 1'b0;
    #(CLK_P);
    check("irq idle clock stopped", irq, 1'b0);
    sw = 1'b1;
    #(CLK_P);
    check("wake irq clock stopped", irq, 1'b1);
    check("status clock stopped", card_in, 1'b0);
    dis = 1'b1;
    #(CLK_P);
    check("wake masked", irq, 1'b0);
    dis = 1'b0;
    #(CLK_P);
    clk_run = 1'b1;
    hold(1'b1, 6);
    check("status after restart", card_in, 1'b1);
    check("irq after restart", irq, 1'b1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule